// File: doc/BRIEF.md
# I2C Master Byte Receiver

This block is the receive half of an I2C master controller. Once a START and an address have been placed on the bus elsewhere, the CPU issues a receive request. The block then makes eight SCL clock pulses from a programmable baud counter and shifts the SDA bits, MSB first, into a shift register. After the eighth falling SCL edge it stops on its own, keeps SCL pulled low and moves the byte into a holding buffer. It also raises the buffer-full flag and the interrupt flag.

The CPU can then start an acknowledge phase. In that phase the block drives the chosen ACK or NACK level on SDA and gives one more SCL pulse. Two sticky error flags report problems. The overflow flag is set when a byte completes while the buffer is still unread. The write-collision flag is set when the CPU tries to write the buffer during a reception. Both bus lines are open-drain and are shown as drive-low enables. SDA is also sampled back as an input.

Top module: `i2c_master_rx`

## Requirements
- R1: After reset, neither SCL nor SDA is driven low, receive-enable and acknowledge-enable read 0, and the buffer-full, interrupt, overflow and write-collision flags are all 0.
- R2: A `rx_start` pulse is taken only while the controller is idle (neither receiving nor acknowledging). When taken, it sets `rx_en` and pulls SCL low. A `rx_start` during a reception or an acknowledge phase has no effect.
- R3: Every SCL half period lasts `baud_reload`+1 clock cycles. SCL changes level each time the baud counter rolls over.
- R4: SDA is sampled at the edge where SCL is released (low to high). The byte is assembled MSB first. SDA is never driven low outside the acknowledge phase.
- R5: Exactly 16*(`baud_reload`+1) cycles after the accepted request, `rx_en` clears, the byte is placed in `rx_buf`, `buf_full` and `irq` go to 1, and SCL stays pulled low.
- R6: A `buf_rd` pulse while no byte is completing clears `buf_full`.
- R7: When a byte completes while `buf_full` is 1, `overflow` is set, `rx_buf` keeps the older byte and the new byte is lost. `overflow` stays 1 until a `ovf_clr` pulse.
- R8: A `buf_wr` while `rx_en` is 1 sets `wcol` and leaves `rx_buf` unchanged. A `buf_wr` while idle loads `buf_wdata` into `rx_buf`. `wcol` stays 1 until a `wcol_clr` pulse.
- R9: An `ack_start` taken while idle sets `ack_en` and drives SDA low when `ack_data` is 0 (ACK) or releases SDA when it is 1 (NACK). SCL is then held low for one half period and released for one half period. At 2*(`baud_reload`+1) cycles SCL is pulled low again, SDA is released, `ack_en` clears and `irq` is set.
- R10: `irq` stays 1 until an `irq_clr` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_reload | input | 8 | Baud counter reload; half period = value+1 clocks |
| rx_start | input | 1 | Pulse: request reception of one byte |
| ack_start | input | 1 | Pulse: request the acknowledge bit |
| ack_data | input | 1 | Acknowledge level: 0 = ACK, 1 = NACK |
| buf_rd | input | 1 | Pulse: CPU read of the holding buffer |
| buf_wr | input | 1 | Pulse: CPU write of the holding buffer |
| buf_wdata | input | 8 | Data for a buffer write |
| ovf_clr | input | 1 | Pulse: clear the overflow flag |
| wcol_clr | input | 1 | Pulse: clear the write-collision flag |
| irq_clr | input | 1 | Pulse: clear the interrupt flag |
| sda_in | input | 1 | Sampled SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| rx_en | output | 1 | Receive-enable status, cleared by hardware |
| ack_en | output | 1 | Acknowledge-enable status, cleared by hardware |
| rx_buf | output | 8 | Holding buffer contents |
| buf_full | output | 1 | Buffer holds an unread byte |
| irq | output | 1 | Interrupt flag |
| overflow | output | 1 | Byte lost because the buffer was full |
| wcol | output | 1 | Buffer write rejected during reception |

## Verification
The assertions assume the following about the inputs:
- Every CPU control input is a single-cycle strobe.
- `baud_reload` does not change during a transfer.
- No slave stretches SCL, because the block does not read SCL back.
- A `buf_rd` never falls in the same cycle as byte completion.

The stimulus drives every strobe for exactly one cycle, at the falling clock edge. It draws a new reload value only between transfers. The slave model changes SDA only after it sees SCL released and the bit taken, so each bit is stable at the sampling edge. Random read-or-skip choices are applied only while the controller is idle.

// File: rtl/i2c_rx_pkg.sv
// Shared types for the I2C master receive path.
// Assumes: consumed by every module of the receiver; no logic here.
package i2c_rx_pkg;
    typedef enum logic [1:0] {
        RXS_IDLE  = 2'd0,
        RXS_SHIFT = 2'd1,
        RXS_ACK   = 2'd2
    } rx_state_e;
endpackage

// File: rtl/i2c_rx_baud.sv
// Baud-rate counter: produces one tick every reload+1 cycles while running.
// Assumes: load is asserted only in a cycle where run is low, and reload is
// stable for the duration of a transfer.
module i2c_rx_baud #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          run,
    input  logic [CW-1:0] reload,
    output logic          tick
);
    logic [CW-1:0] cnt;

    // Count down to zero, then reload; preset on a new operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= reload;
        end else if (run) begin
            if (cnt == '0) cnt <= reload;
            else           cnt <= cnt - 1'b1;
        end
    end

    // Rollover marks the end of an SCL half period.
    assign tick = run && (cnt == '0);
endmodule

// File: rtl/i2c_rx_shift.sv
// Receive shift register: takes one SDA bit per shift enable, MSB first.
// Assumes: clear and shift_en are never high together.
module i2c_rx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         sda,
    output logic [W-1:0] data
);
    // Shift left so that the first received bit ends up in the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n)        data <= '0;
        else if (clear)    data <= '0;
        else if (shift_en) data <= {data[W-2:0], sda};
    end
endmodule

// File: rtl/i2c_rx_hold.sv
// Holding buffer and CPU-facing status flags.
// Assumes: rx_done is a one-cycle pulse at byte completion; rx_busy is high
// for the whole shifting phase, including the completion cycle.
module i2c_rx_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rx_done,
    input  logic [W-1:0] new_byte,
    input  logic         rx_busy,
    input  logic         ack_done,
    input  logic         buf_rd,
    input  logic         buf_wr,
    input  logic [W-1:0] wdata,
    input  logic         ovf_clr,
    input  logic         wcol_clr,
    input  logic         irq_clr,
    output logic [W-1:0] hold,
    output logic         full,
    output logic         irq,
    output logic         ovf,
    output logic         wcol
);
    // Buffer contents and the full flag; a completing byte wins over CPU access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= '0;
            full <= 1'b0;
        end else if (rx_done) begin
            if (!full) begin
                hold <= new_byte;
                full <= 1'b1;
            end
        end else begin
            if (buf_wr && !rx_busy) hold <= wdata;
            if (buf_rd)             full <= 1'b0;
        end
    end

    // Overflow: set when a byte arrives while the buffer is unread.
    always_ff @(posedge clk) begin
        if (!rst_n)                ovf <= 1'b0;
        else if (rx_done && full)  ovf <= 1'b1;
        else if (ovf_clr)          ovf <= 1'b0;
    end

    // Write collision: a CPU write during shifting is refused and flagged.
    always_ff @(posedge clk) begin
        if (!rst_n)                 wcol <= 1'b0;
        else if (buf_wr && rx_busy) wcol <= 1'b1;
        else if (wcol_clr)          wcol <= 1'b0;
    end

    // Interrupt: set at the end of a byte or of an acknowledge phase.
    always_ff @(posedge clk) begin
        if (!rst_n)                   irq <= 1'b0;
        else if (rx_done || ack_done) irq <= 1'b1;
        else if (irq_clr)             irq <= 1'b0;
    end
endmodule

// File: rtl/i2c_master_rx.sv
// I2C master byte receiver: sequences eight SCL pulses to receive one byte,
// then an optional ACK/NACK pulse, and keeps the CPU-side buffer and flags.
// Assumes: START/address handled elsewhere; no slave clock stretching; CPU
// controls are single-cycle strobes.
module i2c_master_rx
    import i2c_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BAUD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BAUD_W-1:0] baud_reload,
    input  logic              rx_start,
    input  logic              ack_start,
    input  logic              ack_data,
    input  logic              buf_rd,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              ovf_clr,
    input  logic              wcol_clr,
    input  logic              irq_clr,
    input  logic              sda_in,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    output logic              rx_en,
    output logic              ack_en,
    output logic [DATA_W-1:0] rx_buf,
    output logic              buf_full,
    output logic              irq,
    output logic              overflow,
    output logic              wcol
);
    localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_FALL = CNT_W'(DATA_W - 1);

    rx_state_e         state;
    logic              scl_low;
    logic              sda_low;
    logic [CNT_W-1:0]  fall_cnt;
    logic              tick;
    logic              idle;
    logic              take_rx;
    logic              take_ack;
    logic              shift_en;
    logic              rx_done;
    logic              ack_done;
    logic [DATA_W-1:0] shreg;

    // Command acceptance: only an idle controller takes a request; receive wins.
    assign idle     = (state == RXS_IDLE);
    assign take_rx  = idle && rx_start;
    assign take_ack = idle && ack_start && !rx_start;

    // Event decode from the baud tick and the present SCL level.
    assign shift_en = (state == RXS_SHIFT) && tick && scl_low;
    assign rx_done  = (state == RXS_SHIFT) && tick && !scl_low && (fall_cnt == LAST_FALL);
    assign ack_done = (state == RXS_ACK) && tick && !scl_low;

    // Sequencer: state, SCL and SDA drive levels, and the falling-edge count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RXS_IDLE;
            scl_low  <= 1'b0;
            sda_low  <= 1'b0;
            fall_cnt <= '0;
        end else begin
            unique case (state)
                RXS_IDLE: begin
                    if (take_rx) begin
                        state    <= RXS_SHIFT;
                        scl_low  <= 1'b1;
                        sda_low  <= 1'b0;
                        fall_cnt <= '0;
                    end else if (take_ack) begin
                        state   <= RXS_ACK;
                        scl_low <= 1'b1;
                        sda_low <= !ack_data;
                    end
                end
                RXS_SHIFT: begin
                    if (tick) begin
                        scl_low <= !scl_low;
                        if (!scl_low) begin
                            if (fall_cnt == LAST_FALL) state <= RXS_IDLE;
                            else                       fall_cnt <= fall_cnt + 1'b1;
                        end
                    end
                end
                RXS_ACK: begin
                    if (tick) begin
                        if (scl_low) begin
                            scl_low <= 1'b0;
                        end else begin
                            scl_low <= 1'b1;
                            sda_low <= 1'b0;
                            state   <= RXS_IDLE;
                        end
                    end
                end
                default: state <= RXS_IDLE;
            endcase
        end
    end

    i2c_rx_baud #(.CW(BAUD_W)) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (take_rx || take_ack),
        .run    (!idle),
        .reload (baud_reload),
        .tick   (tick)
    );

    i2c_rx_shift #(.W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (take_rx),
        .shift_en (shift_en),
        .sda      (sda_in),
        .data     (shreg)
    );

    i2c_rx_hold #(.W(DATA_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_done  (rx_done),
        .new_byte (shreg),
        .rx_busy  (state == RXS_SHIFT),
        .ack_done (ack_done),
        .buf_rd   (buf_rd),
        .buf_wr   (buf_wr),
        .wdata    (buf_wdata),
        .ovf_clr  (ovf_clr),
        .wcol_clr (wcol_clr),
        .irq_clr  (irq_clr),
        .hold     (rx_buf),
        .full     (buf_full),
        .irq      (irq),
        .ovf      (overflow),
        .wcol     (wcol)
    );

    // Status and bus outputs.
    assign rx_en         = (state == RXS_SHIFT);
    assign ack_en        = (state == RXS_ACK);
    assign scl_drive_low = scl_low;
    assign sda_drive_low = sda_low;
endmodule

// File: rtl/i2c_master_rx_chk.sv
// Property checker for the I2C master receiver, bound into every instance.
// Assumes: CPU controls are single-cycle strobes.
module i2c_master_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_start,
    input logic buf_rd,
    input logic buf_wr,
    input logic ovf_clr,
    input logic rx_en,
    input logic ack_en,
    input logic scl_drive_low,
    input logic sda_drive_low,
    input logic buf_full,
    input logic irq,
    input logic overflow,
    input logic wcol
);
    p_start_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_en) |-> $past(rx_start));

    p_sda_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_en |-> !sda_drive_low);

    p_done_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_en) |-> (buf_full && irq && scl_drive_low));

    p_rd_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd && !rx_en) |=> !buf_full);

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !ovf_clr) |=> overflow);

    p_wcol_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_wr && rx_en) |=> wcol);

    p_ack_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_en) |-> (irq && scl_drive_low && !sda_drive_low));
endmodule

bind i2c_master_rx i2c_master_rx_chk u_chk (.*);

// File: tb/tb_i2c_master_rx.sv
`timescale 1ns/1ps
module tb_i2c_master_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] baud_reload = 8'd0;
    logic       rx_start = 1'b0, ack_start = 1'b0, ack_data = 1'b0;
    logic       buf_rd = 1'b0, buf_wr = 1'b0;
    logic [7:0] buf_wdata = 8'd0;
    logic       ovf_clr = 1'b0, wcol_clr = 1'b0, irq_clr = 1'b0;
    logic       sda_in;
    logic       scl_drive_low, sda_drive_low, rx_en, ack_en;
    logic [7:0] rx_buf;
    logic       buf_full, irq, overflow, wcol;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    i2c_master_rx dut (.*);

    // Slave model: presents the next bit after each observed SCL release.
    logic [7:0] slave_byte = 8'h00;
    int rises = 0, base = 0;
    logic prev_low = 1'b0;
    always @(negedge clk) begin
        prev_low <= scl_drive_low;
        if (prev_low && !scl_drive_low) rises <= rises + 1;
    end
    always_comb begin
        int idx;
        idx = rises - base;
        sda_in = (idx >= 0 && idx < 8) ? slave_byte[3'(7 - idx)] : 1'b1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_buf(input logic full, input logic [7:0] old, input logic [7:0] nb);
        return full ? old : nb;
    endfunction

    function automatic logic exp_ovf(input logic full, input logic prev_ovf);
        return full | prev_ovf;
    endfunction

    // Full reception with timing checks around completion (R2, R4, R5).
    task automatic run_rx(input logic [7:0] b, input logic [7:0] r,
                          input logic [7:0] want_buf, input logic want_ovf);
        int hp;
        hp = int'(r) + 1;
        baud_reload = r;
        slave_byte = b;
        base = rises;
        rx_start = 1'b1;
        step(1);
        rx_start = 1'b0;
        chk("R2 rx_en after start", rx_en, 1);
        step(16 * hp - 1);
        chk("R5 rx_en before done", rx_en, 1);
        step(1);
        chk("R5 rx_en cleared", rx_en, 0);
        chk("R4 R7 buffer", rx_buf, want_buf);
        chk("R5 buf_full", buf_full, 1);
        chk("R5 irq", irq, 1);
        chk("R5 scl held low", scl_drive_low, 1);
        chk("R7 overflow", overflow, want_ovf);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1 scl", scl_drive_low, 0);
        chk("R1 sda", sda_drive_low, 0);
        chk("R1 rx_en", rx_en, 0);
        chk("R1 ack_en", ack_en, 0);
        chk("R1 flags", {buf_full, irq, overflow, wcol}, 4'b0000);

        // Directed: reload 3, byte A5, half-period (R3), ignored start and wcol (R2, R8)
        baud_reload = 8'd3;
        slave_byte = 8'hA5;
        base = rises;
        rx_start = 1'b1;
        step(1);
        rx_start = 1'b0;
        chk("R2 scl pulled low", scl_drive_low, 1);
        step(3);
        chk("R3 low phase k=3", scl_drive_low, 1);
        step(1);
        chk("R3 released k=4", scl_drive_low, 0);
        rx_start = 1'b1;
        buf_wr = 1'b1;
        buf_wdata = 8'h3C;
        step(1);
        rx_start = 1'b0;
        buf_wr = 1'b0;
        chk("R8 wcol set", wcol, 1);
        chk("R8 buffer unchanged", rx_buf, 8'h00);
        step(2);
        chk("R3 high phase k=7", scl_drive_low, 0);
        step(1);
        chk("R3 low again k=8", scl_drive_low, 1);
        step(64 - 8 - 1);
        chk("R2 R5 still busy k=63", rx_en, 1);
        step(1);
        chk("R2 R5 done at k=64", rx_en, 0);
        chk("R4 byte A5", rx_buf, 8'hA5);
        chk("R5 flags", {buf_full, irq}, 2'b11);
        step(5);
        chk("R8 wcol sticky", wcol, 1);
        chk("R10 irq sticky", irq, 1);
        wcol_clr = 1'b1; irq_clr = 1'b1;
        step(1);
        wcol_clr = 1'b0; irq_clr = 1'b0;
        chk("R8 wcol cleared", wcol, 0);
        chk("R10 irq cleared", irq, 0);

        // Overflow: second byte with the buffer unread (R7)
        run_rx(8'h5A, 8'd0, 8'hA5, 1'b1);
        step(7);
        chk("R7 overflow sticky", overflow, 1);
        ovf_clr = 1'b1;
        step(1);
        ovf_clr = 1'b0;
        chk("R7 overflow cleared", overflow, 0);
        buf_rd = 1'b1;
        step(1);
        buf_rd = 1'b0;
        chk("R6 read clears full", buf_full, 0);
        buf_wr = 1'b1; buf_wdata = 8'h96;
        step(1);
        buf_wr = 1'b0;
        chk("R8 idle write loads", rx_buf, 8'h96);
        chk("R8 no wcol when idle", wcol, 0);

        // Acknowledge phases (R9), with a start request while busy (R2)
        for (int a = 0; a < 2; a++) begin
            int hp;
            hp = 3 - a;
            baud_reload = 8'(hp - 1);
            ack_data = a[0] ? 1'b0 : 1'b1;
            irq_clr = 1'b1;
            step(1);
            irq_clr = 1'b0;
            ack_start = 1'b1;
            step(1);
            ack_start = 1'b0;
            chk("R9 ack_en set", ack_en, 1);
            chk("R9 sda level", sda_drive_low, !ack_data);
            rx_start = 1'b1;
            step(1);
            rx_start = 1'b0;
            chk("R2 start ignored in ack", rx_en, 0);
            step(hp - 2);
            chk("R9 scl low phase", scl_drive_low, 1);
            step(1);
            chk("R9 scl released", scl_drive_low, 0);
            step(hp - 1);
            chk("R9 still high", {scl_drive_low, ack_en}, 2'b01);
            step(1);
            chk("R9 ack_en cleared", ack_en, 0);
            chk("R9 scl low at end", scl_drive_low, 1);
            chk("R9 sda released", sda_drive_low, 0);
            chk("R9 irq", irq, 1);
        end

        // Random transfers against the bench model (R4, R5, R6, R7)
        begin
            logic       m_full;
            logic       m_ovf;
            logic [7:0] m_buf;
            m_full = buf_full; m_ovf = 1'b0; m_buf = rx_buf;
            for (int i = 0; i < 24; i++) begin
                logic [7:0] b;
                logic [7:0] r;
                b = 8'($urandom);
                r = 8'($urandom_range(0, 4));
                if ($urandom_range(0, 2) != 0) begin
                    buf_rd = 1'b1;
                    step(1);
                    buf_rd = 1'b0;
                    m_full = 1'b0;
                    chk("R6 random read", buf_full, 0);
                end
                run_rx(b, r, exp_buf(m_full, m_buf, b), exp_ovf(m_full, m_ovf));
                m_ovf = exp_ovf(m_full, m_ovf);
                m_buf = exp_buf(m_full, m_buf, b);
                m_full = 1'b1;
                step(int'($urandom_range(1, 3)));
            end
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule